// File: doc/BRIEF.md
# Iterative 32-Point Radix-2 FFT Engine

The engine computes a 32-point complex discrete Fourier transform on 8-bit fixed-point samples using the radix-2 decimation-in-time method. Samples are written one at a time through an indexed load port into an input register bank. A start pulse then launches the transform. Sixteen butterfly units run in parallel and process one full stage per clock cycle. After five cycles the spectrum sits in an output register bank, where an indexed read port returns it in natural frequency order.

A stage multiplexer sources the butterfly operands. It takes them from the input bank on the first pass and from a stage register that holds the previous pass's results on the remaining passes. A small controller steps the stage count. That count sets operand pairing and twiddle addressing. Every butterfly result is halved with rounding, so the complete transform is scaled by 1/32 and stays within 8 bits.

Top module: `fft32_engine`

## Requirements
- R1: After reset, `done_o` is low and the read port returns zero real and zero imaginary parts for every index.
- R2: A sample written with `ld_valid_i` high at load index n is sample x[n] of the transform input. The result at read index k is spectrum bin X[k], so both sides use natural order.
- R3: A `start_i` pulse taken while idle starts a transform. `done_o` is high during exactly the fifth cycle after the start edge, for one cycle only. The new spectrum is readable in that same cycle.
- R4: A `start_i` pulse taken while a transform runs is ignored. The transform neither restarts nor produces a second `done_o` pulse.
- R5: Load writes taken while a transform runs are ignored. The input bank keeps the samples loaded before the start.
- R6: Each butterfly with operands a, b and twiddle W produces two outputs. Each is (64·a + 64 + (b·W)_q12) >>> 7, computed separately for the real and imaginary parts. Here (b·W)_q12 is the exact integer product with W in Q1.6 units, the + sign gives the upper output and the − sign the lower output, and the shift is arithmetic. Each result is then clamped to the range [−128, 127].
- R7: Twiddle k, for k from 0 to 15, has real part round(64·cos(2πk/32)) and imaginary part −round(64·sin(2πk/32)).
- R8: The read port is combinational on `rd_idx_i`. Output bank contents change only in the cycle in which `done_o` is high.
- R9: Overall scaling is 1/32. A constant input c gives X[0] = c with all other bins zero. An impulse of 64 at x[0] gives 2 + 0j in every bin.
- R10: Stage s, numbered 0 to 4, pairs elements whose indices differ by a span of 2^s. Butterfly j uses twiddle exponent (j mod 2^s)·2^(4−s).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_valid_i | input | 1 | Load strobe for one sample |
| ld_idx_i | input | 5 | Natural time index of the loaded sample |
| ld_re_i | input | 8 | Sample real part, two's complement |
| ld_im_i | input | 8 | Sample imaginary part, two's complement |
| start_i | input | 1 | Launches a transform when idle |
| done_o | output | 1 | One-cycle pulse when the spectrum is latched |
| rd_idx_i | input | 5 | Frequency bin to read |
| rd_re_o | output | 8 | Bin real part |
| rd_im_o | output | 8 | Bin imaginary part |

## Verification
On every cycle, the assertions check the controller's sequence. A start taken while idle enters stage 0. Each busy cycle advances the stage by exactly one, even when a stray start arrives. The last stage is followed by a single-cycle done. The output bank stays frozen between completions. Only the bench scenarios can show the arithmetic: the bit-reversed load mapping, twiddle values, rounding and clamping, and the 1/32 scaling. The bench compares whole spectra against an independent fixed-point model and closed-form impulse and DC cases. It also shows that loads and starts issued mid-transform leave the next result unchanged.

// File: rtl/fft32_pkg.sv
package fft32_pkg;
  localparam int NPT    = 32;
  localparam int LOG2N  = 5;
  localparam int NBFLY  = NPT / 2;
  localparam int STG_W  = $clog2(LOG2N);
  localparam int TW_W   = 8;
  localparam int TW_FRAC = 6;
  localparam int TWA_W  = LOG2N - 1;

  typedef enum logic {ST_IDLE, ST_RUN} fsm_e;

  function automatic logic [LOG2N-1:0] bitrev(input logic [LOG2N-1:0] v);
    logic [LOG2N-1:0] r;
    for (int i = 0; i < LOG2N; i++) r[i] = v[LOG2N-1-i];
    return r;
  endfunction

  // upper operand index of butterfly j in stage s
  function automatic logic [LOG2N-1:0] bfly_top(input int j, input int s);
    int t;
    t = ((j >> s) << (s + 1)) | (j & ((1 << s) - 1));
    return LOG2N'(t);
  endfunction

  function automatic logic [LOG2N-1:0] bfly_span(input int s);
    return LOG2N'(1 << s);
  endfunction

  function automatic logic [TWA_W-1:0] bfly_tw(input int j, input int s);
    int t;
    t = (j & ((1 << s) - 1)) << (LOG2N - 1 - s);
    return TWA_W'(t);
  endfunction
endpackage

// File: rtl/fft32_csel_add.sv
module fft32_csel_add #(
  parameter int WIDTH = 18,
  parameter int BLK   = 6
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o
);
  localparam int NBLK  = (WIDTH + BLK - 1) / BLK;
  localparam int LASTW = WIDTH - (NBLK - 1) * BLK;

  logic [NBLK-1:0] c;
  assign c[0] = cin_i;

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    localparam int LO = g * BLK;
    if (g == 0) begin : g_ripple
      logic [BLK:0] s;
      assign s = {1'b0, a_i[LO+:BLK]} + {1'b0, b_i[LO+:BLK]} + {{BLK{1'b0}}, c[0]};
      assign sum_o[LO+:BLK] = s[BLK-1:0];
      assign c[1] = s[BLK];
    end else if (g == NBLK - 1) begin : g_last
      logic [LASTW-1:0] s0, s1;
      assign s0 = a_i[LO+:LASTW] + b_i[LO+:LASTW];
      assign s1 = s0 + LASTW'(1);
      assign sum_o[LO+:LASTW] = c[g] ? s1 : s0;
    end else begin : g_mid
      logic [BLK:0] s0, s1;
      assign s0 = {1'b0, a_i[LO+:BLK]} + {1'b0, b_i[LO+:BLK]};
      assign s1 = {1'b0, a_i[LO+:BLK]} + {1'b0, b_i[LO+:BLK]} + (BLK+1)'(1);
      assign sum_o[LO+:BLK] = c[g] ? s1[BLK-1:0] : s0[BLK-1:0];
      assign c[g+1] = c[g] ? s1[BLK] : s0[BLK];
    end
  end
endmodule

// File: rtl/fft32_tw_rom.sv
module fft32_tw_rom
  import fft32_pkg::*;
(
  input  logic [TWA_W-1:0]      idx_i,
  output logic signed [TW_W-1:0] w_re_o,
  output logic signed [TW_W-1:0] w_im_o
);
  localparam int QN = NBFLY / 2;
  // quarter-wave cosine in Q1.6, entry q = round(64*cos(q*pi/16))
  localparam logic signed [TW_W-1:0] COSQ [QN+1] = '{
    8'sd64, 8'sd63, 8'sd59, 8'sd53, 8'sd45, 8'sd36, 8'sd24, 8'sd12, 8'sd0
  };

  always_comb begin
    int k;
    k = int'(idx_i);
    if (k <= QN) begin
      w_re_o = COSQ[k];
      w_im_o = -COSQ[QN-k];
    end else begin
      w_re_o = -COSQ[2*QN-k];
      w_im_o = -COSQ[k-QN];
    end
  end
endmodule

// File: rtl/fft32_bfly.sv
module fft32_bfly
  import fft32_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADD_BLK = 6
) (
  input  logic signed [DATA_W-1:0] a_re_i,
  input  logic signed [DATA_W-1:0] a_im_i,
  input  logic signed [DATA_W-1:0] b_re_i,
  input  logic signed [DATA_W-1:0] b_im_i,
  input  logic signed [TW_W-1:0]   w_re_i,
  input  logic signed [TW_W-1:0]   w_im_i,
  output logic signed [DATA_W-1:0] x_re_o,
  output logic signed [DATA_W-1:0] x_im_o,
  output logic signed [DATA_W-1:0] y_re_o,
  output logic signed [DATA_W-1:0] y_im_o
);
  localparam int PW   = DATA_W + TW_W;
  localparam int AW   = PW + 2;
  localparam int SH   = TW_FRAC + 1;
  localparam int MAXI = 2**(DATA_W-1) - 1;
  localparam int MINI = -(2**(DATA_W-1));
  localparam logic signed [AW-1:0] RND = AW'(2**TW_FRAC);

  logic signed [PW-1:0] m_rr, m_ii, m_ri, m_ir;
  logic signed [AW-1:0] p_re, p_im, a_re_x, a_im_x;
  logic [AW-1:0] s_xr, s_xi, s_yr, s_yi;

  assign m_rr = b_re_i * w_re_i;
  assign m_ii = b_im_i * w_im_i;
  assign m_ri = b_re_i * w_im_i;
  assign m_ir = b_im_i * w_re_i;

  assign p_re = AW'(m_rr) - AW'(m_ii);
  assign p_im = AW'(m_ri) + AW'(m_ir);

  assign a_re_x = (AW'(a_re_i) <<< TW_FRAC) + RND;
  assign a_im_x = (AW'(a_im_i) <<< TW_FRAC) + RND;

  fft32_csel_add #(.WIDTH(AW), .BLK(ADD_BLK)) u_add_xr (
    .a_i(a_re_x), .b_i(p_re), .cin_i(1'b0), .sum_o(s_xr));
  fft32_csel_add #(.WIDTH(AW), .BLK(ADD_BLK)) u_add_xi (
    .a_i(a_im_x), .b_i(p_im), .cin_i(1'b0), .sum_o(s_xi));
  fft32_csel_add #(.WIDTH(AW), .BLK(ADD_BLK)) u_sub_yr (
    .a_i(a_re_x), .b_i(~p_re), .cin_i(1'b1), .sum_o(s_yr));
  fft32_csel_add #(.WIDTH(AW), .BLK(ADD_BLK)) u_sub_yi (
    .a_i(a_im_x), .b_i(~p_im), .cin_i(1'b1), .sum_o(s_yi));

  function automatic logic signed [DATA_W-1:0] scale_sat(input logic [AW-1:0] v);
    logic signed [AW-1:0] sh;
    sh = $signed(v) >>> SH;
    if (sh > MAXI)      return DATA_W'(MAXI);
    else if (sh < MINI) return DATA_W'(MINI);
    else                return sh[DATA_W-1:0];
  endfunction

  assign x_re_o = scale_sat(s_xr);
  assign x_im_o = scale_sat(s_xi);
  assign y_re_o = scale_sat(s_yr);
  assign y_im_o = scale_sat(s_yi);
endmodule

// File: rtl/fft32_ctrl.sv
module fft32_ctrl
  import fft32_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             first_o,
  output logic             last_o,
  output logic [STG_W-1:0] stage_o,
  output logic             done_o
);
  localparam logic [STG_W-1:0] LAST_STG = STG_W'(LOG2N - 1);

  fsm_e state_q;
  logic [STG_W-1:0] stage_q;
  logic done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      stage_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          stage_q <= '0;
        end
        ST_RUN: if (stage_q == LAST_STG) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end else begin
          stage_q <= stage_q + STG_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q == ST_RUN);
  assign first_o = busy_o && (stage_q == '0);
  assign last_o  = busy_o && (stage_q == LAST_STG);
  assign stage_o = stage_q;
  assign done_o  = done_q;
endmodule

// File: rtl/fft32_engine.sv
module fft32_engine
  import fft32_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADD_BLK = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ld_valid_i,
  input  logic [LOG2N-1:0]         ld_idx_i,
  input  logic signed [DATA_W-1:0] ld_re_i,
  input  logic signed [DATA_W-1:0] ld_im_i,
  input  logic                     start_i,
  output logic                     done_o,
  input  logic [LOG2N-1:0]         rd_idx_i,
  output logic signed [DATA_W-1:0] rd_re_o,
  output logic signed [DATA_W-1:0] rd_im_o
);
  logic busy, first, last;
  logic [STG_W-1:0] stage;

  fft32_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .busy_o  (busy),
    .first_o (first),
    .last_o  (last),
    .stage_o (stage),
    .done_o  (done_o)
  );

  logic signed [DATA_W-1:0] in_re  [NPT], in_im  [NPT];
  logic signed [DATA_W-1:0] st_re  [NPT], st_im  [NPT];
  logic signed [DATA_W-1:0] out_re [NPT], out_im [NPT];
  logic signed [DATA_W-1:0] src_re [NPT], src_im [NPT];
  logic signed [DATA_W-1:0] nxt_re [NPT], nxt_im [NPT];

  logic [LOG2N-1:0] top_idx [NBFLY], bot_idx [NBFLY];
  logic [TWA_W-1:0] tw_idx  [NBFLY];
  logic signed [DATA_W-1:0] x_re [NBFLY], x_im [NBFLY], y_re [NBFLY], y_im [NBFLY];

  // operand pairing and twiddle exponent per stage
  always_comb begin
    for (int j = 0; j < NBFLY; j++) begin
      top_idx[j] = bfly_top(j, int'(stage));
      bot_idx[j] = top_idx[j] | bfly_span(int'(stage));
      tw_idx[j]  = bfly_tw(j, int'(stage));
    end
  end

  // stage multiplexer
  always_comb begin
    for (int n = 0; n < NPT; n++) begin
      src_re[n] = first ? in_re[n] : st_re[n];
      src_im[n] = first ? in_im[n] : st_im[n];
    end
  end

  for (genvar j = 0; j < NBFLY; j++) begin : g_bf
    logic signed [TW_W-1:0] w_re, w_im;

    fft32_tw_rom u_rom (
      .idx_i  (tw_idx[j]),
      .w_re_o (w_re),
      .w_im_o (w_im)
    );

    fft32_bfly #(.DATA_W(DATA_W), .ADD_BLK(ADD_BLK)) u_bf (
      .a_re_i (src_re[top_idx[j]]),
      .a_im_i (src_im[top_idx[j]]),
      .b_re_i (src_re[bot_idx[j]]),
      .b_im_i (src_im[bot_idx[j]]),
      .w_re_i (w_re),
      .w_im_i (w_im),
      .x_re_o (x_re[j]),
      .x_im_o (x_im[j]),
      .y_re_o (y_re[j]),
      .y_im_o (y_im[j])
    );
  end

  // scatter butterfly results back to their slots
  always_comb begin
    nxt_re = st_re;
    nxt_im = st_im;
    for (int j = 0; j < NBFLY; j++) begin
      nxt_re[top_idx[j]] = x_re[j];
      nxt_im[top_idx[j]] = x_im[j];
      nxt_re[bot_idx[j]] = y_re[j];
      nxt_im[bot_idx[j]] = y_im[j];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 0; n < NPT; n++) begin
        in_re[n] <= '0;
        in_im[n] <= '0;
      end
    end else if (ld_valid_i && !busy) begin
      in_re[bitrev(ld_idx_i)] <= ld_re_i;
      in_im[bitrev(ld_idx_i)] <= ld_im_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 0; n < NPT; n++) begin
        st_re[n] <= '0;
        st_im[n] <= '0;
      end
    end else if (busy && !last) begin
      st_re <= nxt_re;
      st_im <= nxt_im;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 0; n < NPT; n++) begin
        out_re[n] <= '0;
        out_im[n] <= '0;
      end
    end else if (last) begin
      out_re <= nxt_re;
      out_im <= nxt_im;
    end
  end

  assign rd_re_o = out_re[rd_idx_i];
  assign rd_im_o = out_im[rd_idx_i];
endmodule

// File: rtl/fft32_chk.sv
module fft32_chk #(
  parameter int NSTG   = 5,
  parameter int STG_W  = 3,
  parameter int IDX_W  = 5,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy,
  input logic [STG_W-1:0]  stage,
  input logic              done_o,
  input logic [IDX_W-1:0]  rd_idx_i,
  input logic [DATA_W-1:0] rd_re_o,
  input logic [DATA_W-1:0] rd_im_o
);
  localparam logic [STG_W-1:0] LAST_STG = STG_W'(NSTG - 1);

  assert_start_launch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && start_i) |=> (busy && stage == '0));

  assert_stage_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && stage != LAST_STG) |=> (busy && stage == $past(stage) + STG_W'(1)));

  assert_last_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && stage == LAST_STG) |=> (done_o && !busy));

  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_run_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy));

  assert_out_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && $stable(rd_idx_i)) |-> ($stable(rd_re_o) && $stable(rd_im_o)));
endmodule

bind fft32_engine fft32_chk #(
  .NSTG   (fft32_pkg::LOG2N),
  .STG_W  (fft32_pkg::STG_W),
  .IDX_W  (fft32_pkg::LOG2N),
  .DATA_W (DATA_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy     (busy),
  .stage    (stage),
  .done_o   (done_o),
  .rd_idx_i (rd_idx_i),
  .rd_re_o  (rd_re_o),
  .rd_im_o  (rd_im_o)
);

// File: tb/tb_fft32_engine.sv
module tb_fft32_engine;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 1'b0;
  logic [4:0] ld_idx = '0;
  logic signed [7:0] ld_re = '0, ld_im = '0;
  logic start = 1'b0;
  logic done;
  logic [4:0] rd_idx = '0;
  logic signed [7:0] rd_re, rd_im;

  int checks = 0;
  int errors = 0;
  int xr [N], xi [N], er [N], ei [N];
  int twr [16], twi [16];
  int unsigned seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  fft32_engine dut (
    .clk_i (clk), .rst_ni (rst_n),
    .ld_valid_i (ld_valid), .ld_idx_i (ld_idx), .ld_re_i (ld_re), .ld_im_i (ld_im),
    .start_i (start), .done_o (done),
    .rd_idx_i (rd_idx), .rd_re_o (rd_re), .rd_im_o (rd_im)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int brev(input int n);
    int r = 0;
    for (int i = 0; i < 5; i++) if (n & (1 << i)) r |= 1 << (4 - i);
    return r;
  endfunction

  function automatic int rnd_half(input real r);
    return (r >= 0.0) ? $rtoi(r + 0.5) : $rtoi(r - 0.5);
  endfunction

  function automatic int clamp8(input int v);
    return (v > 127) ? 127 : ((v < -128) ? -128 : v);
  endfunction

  function automatic int rand8();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'hff) - 128;
  endfunction

  // fixed-point reference per R2, R6, R7, R10
  task automatic model();
    int vr [N], vi [N];
    for (int n = 0; n < N; n++) begin
      vr[brev(n)] = xr[n];
      vi[brev(n)] = xi[n];
    end
    for (int s = 0; s < 5; s++) begin
      int h = 1 << s;
      for (int j = 0; j < 16; j++) begin
        int t = ((j >> s) << (s + 1)) | (j & (h - 1));
        int b = t + h;
        int k = (j & (h - 1)) << (4 - s);
        int pr = vr[b] * twr[k] - vi[b] * twi[k];
        int pi = vr[b] * twi[k] + vi[b] * twr[k];
        int ar = vr[t] * 64 + 64;
        int ai = vi[t] * 64 + 64;
        vr[t] = clamp8((ar + pr) >>> 7);
        vi[t] = clamp8((ai + pi) >>> 7);
        vr[b] = clamp8((ar - pr) >>> 7);
        vi[b] = clamp8((ai - pi) >>> 7);
      end
    end
    er = vr;
    ei = vi;
  endtask

  task automatic load_all();
    for (int n = 0; n < N; n++) begin
      @(negedge clk);
      ld_valid = 1'b1; ld_idx = 5'(n); ld_re = 8'(xr[n]); ld_im = 8'(xi[n]);
    end
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  // start, watch done for 8 cycles; optional mid-run starts and loads by cycle mask
  task automatic run(input string req, input int start_mask, input int load_mask);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      check(done == (i == 5), req, int'(done), int'(i == 5));
      start = start_mask[i];
      ld_valid = load_mask[i];
      ld_idx = 5'(i);
      ld_re = 8'sd77;
      ld_im = -8'sd77;
    end
    start = 1'b0;
    ld_valid = 1'b0;
  endtask

  task automatic compare(input string req);
    for (int k = 0; k < N; k++) begin
      rd_idx = 5'(k);
      #1;
      check(int'(rd_re) == er[k], req, int'(rd_re), er[k]);
      check(int'(rd_im) == ei[k], req, int'(rd_im), ei[k]);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    for (int k = 0; k < N; k++) begin
      er[k] = 0; ei[k] = 0;
    end
    compare("R1 reset read");
  endtask

  task automatic t_impulse();
    for (int n = 0; n < N; n++) begin xr[n] = 0; xi[n] = 0; end
    xr[0] = 64;
    load_all();
    run("R3 done timing", 0, 0);
    for (int k = 0; k < N; k++) begin er[k] = 2; ei[k] = 0; end
    compare("R9 impulse");
  endtask

  task automatic t_dc();
    for (int n = 0; n < N; n++) begin xr[n] = 100; xi[n] = -40; end
    load_all();
    run("R3 done timing", 0, 0);
    for (int k = 0; k < N; k++) begin er[k] = 0; ei[k] = 0; end
    er[0] = 100; ei[0] = -40;
    compare("R9 dc");
  endtask

  task automatic t_shifted_impulse();
    for (int n = 0; n < N; n++) begin xr[n] = 0; xi[n] = 0; end
    xr[1] = 64; xi[3] = -64;
    load_all();
    run("R3 done timing", 0, 0);
    model();
    compare("R2 R7 index order and twiddles");
  endtask

  task automatic t_random(input int rounds);
    for (int r = 0; r < rounds; r++) begin
      for (int n = 0; n < N; n++) begin xr[n] = rand8(); xi[n] = rand8(); end
      load_all();
      run("R3 done timing", 0, 0);
      model();
      compare("R6 R7 R10 random spectrum");
    end
  endtask

  task automatic t_saturate();
    for (int r = 0; r < 3; r++) begin
      for (int n = 0; n < N; n++) begin
        xr[n] = (rand8() < 0) ? -128 : 127;
        xi[n] = (rand8() < 0) ? -128 : 127;
      end
      load_all();
      run("R3 done timing", 0, 0);
      model();
      compare("R6 extreme inputs clamp");
    end
  endtask

  task automatic t_start_busy();
    for (int n = 0; n < N; n++) begin xr[n] = rand8(); xi[n] = rand8(); end
    load_all();
    run("R4 start while busy", 32'b0001_1110, 0);
    model();
    compare("R4 result after stray starts");
  endtask

  task automatic t_load_busy();
    for (int n = 0; n < N; n++) begin xr[n] = rand8(); xi[n] = rand8(); end
    load_all();
    run("R3 done timing", 0, 32'b0001_1110);
    model();
    compare("R5 first run");
    run("R3 done timing", 0, 0);
    compare("R5 rerun without reload");
  endtask

  task automatic t_hold();
    repeat (10) @(negedge clk);
    compare("R8 output held");
  endtask

  initial begin
    for (int k = 0; k < 16; k++) begin
      twr[k] = rnd_half(64.0 * $cos(2.0 * 3.14159265358979 * k / 32.0));
      twi[k] = -rnd_half(64.0 * $sin(2.0 * 3.14159265358979 * k / 32.0));
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_impulse();
    t_dc();
    t_shifted_impulse();
    t_random(4);
    t_saturate();
    t_start_busy();
    t_load_busy();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL R3 watchdog actual %0d expected %0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule